// File: doc/BRIEF.md
# Clock Ratio Speed Mode Detector

This block watches a master clock and a frame clock and works out how many master-clock cycles fit into one frame. From that count it picks a sampling speed mode: half, normal or double. Two select pins either fix the mode or let the block choose it. When the mode is fixed, the block only checks that the measured ratio is one that mode allows. In auto mode, the block chooses the mode from the ratio. The measured ratio is reported as a small code next to a valid flag.

Everything runs on one free-running reference clock. The master clock and the frame clock come in as sampled data, each through a two-stage synchronizer, so the master clock must run at no more than half the reference rate. The frame clock is assumed to be locked to the master clock, with any phase between them.

A watchdog counts reference cycles since the last master-clock rising edge. If the master clock stops, the block drops its result and raises the power-save flag. One new master-clock edge brings it back. Out of reset, the block stays in power-save until both clocks have shown a rising edge.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, psave_o is 1, valid_o is 0, ratio_o is 0 and mode_o is 2'b00.
- R2: After reset, psave_o stays 1 until at least one master-clock rising edge and at least one frame-clock rising edge have both been observed, and then falls to 0.
- R3: A measurement is the number of master-clock rising edges between two consecutive frame-clock rising edges. valid_o rises, and ratio_o takes the code of the measurement, when two consecutive measurements are equal and accepted. The codes are: 0 = none, 1 = 128, 2 = 192, 3 = 256, 4 = 384, 5 = 512, 6 = 768, 7 = 1024, 8 = 1536.
- R4: With sel_i = 2'b11 (auto) and a valid result, mode_o is 2'b01 (double) for codes 1 to 4, 2'b00 (normal) for codes 5 and 6, and 2'b10 (half) for codes 7 and 8. In auto mode every listed ratio is accepted.
- R5: With sel_i = 2'b00 (normal), 2'b01 (double) or 2'b10 (half), mode_o equals sel_i one cycle later. The accepted codes are 3 to 6 for normal, 1 to 4 for double and 5 to 8 for half.
- R6: A measurement that is not accepted clears valid_o and sets ratio_o to 0.
- R7: When STOP_CYCLES reference cycles pass with no master-clock rising edge, psave_o becomes 1 and valid_o and ratio_o are cleared.
- R8: After a master-clock stop, the first master-clock rising edge ends power-save, even if the frame clock stays idle.
- R9: An accepted measurement that differs from the one before it leaves valid_o and ratio_o unchanged.
- R10: In auto mode, mode_o is 2'b00 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock, sampled as data |
| lrck_i | input | 1 | Frame clock, sampled as data |
| sel_i | input | 2 | Speed select: 00 normal, 01 double, 10 half, 11 auto |
| mode_o | output | 2 | Resolved speed mode: 00 normal, 01 double, 10 half |
| ratio_o | output | 4 | Detected ratio code (see R3) |
| valid_o | output | 1 | A ratio has been confirmed |
| psave_o | output | 1 | Power-save is active |

## Verification
The hardest case to reach is R9, a stream of accepted ratios that never repeat. It only occurs if every frame is a complete, clean frame of a new length. A broken frame would instead give an unlisted count and clear the result. The stimulus changes the frame length only at a frame-clock rising edge, and it alternates between 256 and 512 cycles per frame. The power-up path is also hard to isolate. The bench first runs the frame clock alone, long enough for the watchdog to trip, and only then starts the master clock. A behavioural model compares every output on every cycle.

// File: rtl/ckdet_pkg.sv
package ckdet_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_HALF   = 2'b10,
        SPD_AUTO   = 2'b11
    } spd_e;

    // speed mode chosen in auto operation for a ratio code
    function automatic logic [1:0] code_to_mode(input logic [CODE_W-1:0] code);
        logic [1:0] m;
        if (code >= 4'd1 && code <= 4'd4)      m = SPD_DOUBLE;
        else if (code == 4'd7 || code == 4'd8) m = SPD_HALF;
        else                                   m = SPD_NORMAL;
        return m;
    endfunction

endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], in_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mclk_watchdog.sv
module mclk_watchdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic stall_nx_o,
    output logic stall_q_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          stall_d, stall_q;

    always_comb begin
        if (tick_i)                    cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))  cnt_d = cnt_q + 1'b1;
        else                           cnt_d = cnt_q;
        stall_d = (cnt_d == CW'(LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            stall_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            stall_q <= stall_d;
        end
    end

    assign stall_nx_o = stall_d;
    assign stall_q_o  = stall_q;

    // a master-clock edge always releases the stop flag on the next cycle
    assert_wd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> !stall_q);
endmodule

// File: rtl/ratio_classify.sv
module ratio_classify #(
    parameter int CNT_W = 12,
    parameter int BASE  = 128,
    parameter int NUM   = 8
) (
    input  logic [CNT_W-1:0]             count_i,
    input  logic [1:0]                   sel_i,
    output logic [ckdet_pkg::CODE_W-1:0] code_o,
    output logic                         accept_o
);
    import ckdet_pkg::*;

    logic [NUM-1:0]    hit;
    logic [CODE_W-1:0] lo;

    // listed ratios: BASE and 1.5*BASE, each doubled per step
    for (genvar i = 0; i < NUM; i++) begin : g_ratio
        localparam int RATIO = (((i % 2) == 0) ? BASE : (BASE * 3) / 2) << (i / 2);
        assign hit[i] = (count_i == CNT_W'(RATIO));
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (hit[i]) code_o = CODE_W'(i + 1);
        end
        case (sel_i)
            SPD_DOUBLE: lo = 4'd1;
            SPD_NORMAL: lo = 4'd3;
            default:    lo = 4'd5;
        endcase
        if (sel_i == SPD_AUTO) accept_o = (code_o != '0);
        else                   accept_o = (code_o >= lo) && (code_o <= lo + 4'd3);
    end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect #(
    parameter int CNT_W       = 12,
    parameter int STOP_CYCLES = 256,
    parameter int SYNC_STAGES = 2,
    parameter int BASE_RATIO  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_i,
    input  logic       lrck_i,
    input  logic [1:0] sel_i,
    output logic [1:0] mode_o,
    output logic [3:0] ratio_o,
    output logic       valid_o,
    output logic       psave_o
);
    import ckdet_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  prev;
        logic              prev_ok;
        logic              started;
        logic              mseen;
        logic              lseen;
        logic              psave;
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [1:0]        mode;
    } det_t;

    det_t st_d, st_q;

    logic              m_rise, l_rise;
    logic              stall_nx, stall_q;
    logic [CODE_W-1:0] meas_code;
    logic              meas_ok;

    edge_rise #(.STAGES(SYNC_STAGES)) u_msync (
        .clk(clk), .rst_n(rst_n), .in_i(mclk_i), .rise_o(m_rise));

    edge_rise #(.STAGES(SYNC_STAGES)) u_lsync (
        .clk(clk), .rst_n(rst_n), .in_i(lrck_i), .rise_o(l_rise));

    mclk_watchdog #(.LIMIT(STOP_CYCLES)) u_wd (
        .clk(clk), .rst_n(rst_n), .tick_i(m_rise),
        .stall_nx_o(stall_nx), .stall_q_o(stall_q));

    ratio_classify #(.CNT_W(CNT_W), .BASE(BASE_RATIO), .NUM(8)) u_cls (
        .count_i(st_q.cnt), .sel_i(sel_i),
        .code_o(meas_code), .accept_o(meas_ok));

    always_comb begin
        st_d       = st_q;
        st_d.lseen = st_q.lseen | l_rise;
        if (stall_nx) begin
            st_d.mseen   = 1'b0;
            st_d.started = 1'b0;
            st_d.prev_ok = 1'b0;
            st_d.cnt     = '0;
            st_d.valid   = 1'b0;
            st_d.code    = '0;
        end else begin
            st_d.mseen = st_q.mseen | m_rise;
            if (l_rise) begin
                if (st_q.started) begin
                    if (!meas_ok) begin
                        st_d.valid = 1'b0;
                        st_d.code  = '0;
                    end else if (st_q.prev_ok && st_q.cnt == st_q.prev) begin
                        st_d.valid = 1'b1;
                        st_d.code  = meas_code;
                    end
                    st_d.prev    = st_q.cnt;
                    st_d.prev_ok = 1'b1;
                end
                st_d.started = 1'b1;
                st_d.cnt     = m_rise ? CNT_W'(1) : '0;
            end else if (m_rise && st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.psave = stall_nx | ~(st_d.mseen & st_d.lseen);
        if (sel_i != SPD_AUTO) st_d.mode = sel_i;
        else if (st_d.valid)   st_d.mode = code_to_mode(st_d.code);
        else                   st_d.mode = SPD_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.psave <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign ratio_o = st_q.code;
    assign valid_o = st_q.valid;
    assign psave_o = st_q.psave;

    assert_valid_has_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (ratio_o != '0));

    assert_manual_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != SPD_AUTO) |=> (mode_o == $past(sel_i)));

    assert_psave_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        psave_o |-> !valid_o);

    assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rise |=> ($stable(ratio_o) || stall_q));
endmodule

// File: tb/tb_clk_ratio_detect.sv
module tb_clk_ratio_detect;
    localparam int STOP = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0;
    logic       lrck = 1'b0;
    logic [1:0] sel = 2'b11;
    logic [1:0] mode_o;
    logic [3:0] ratio_o;
    logic       valid_o, psave_o;

    clk_ratio_detect #(.STOP_CYCLES(STOP)) dut (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .lrck_i(lrck), .sel_i(sel),
        .mode_o(mode_o), .ratio_o(ratio_o), .valid_o(valid_o), .psave_o(psave_o));

    always #4 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    // stimulus generator state
    bit mclk_run = 0, lrck_run = 0, alt = 0;
    int half = 256, half_req = 256, ha = 256, hb = 512, lcnt = 0;

    // reference model state
    bit hm[3], hl[3];
    int m_wd, m_cnt, m_prev, m_code, m_mode;
    bit m_stall, m_mseen, m_lseen, m_psave, m_started, m_prev_ok, m_valid;

    function automatic int rcode(int n);
        case (n)
            128: return 1;   192: return 2;   256: return 3;  384: return 4;
            512: return 5;   768: return 6;   1024: return 7; 1536: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic bit accepted(int c, int s);
        case (s)
            3: return c != 0;
            1: return c >= 1 && c <= 4;
            0: return c >= 3 && c <= 6;
            default: return c >= 5 && c <= 8;
        endcase
    endfunction

    function automatic int auto_mode(int c);
        if (c >= 1 && c <= 4) return 1;
        if (c == 7 || c == 8) return 2;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin hm[i] = 0; hl[i] = 0; end
            m_wd = 0; m_cnt = 0; m_prev = 0; m_code = 0; m_mode = 0;
            m_stall = 0; m_mseen = 0; m_lseen = 0; m_psave = 1;
            m_started = 0; m_prev_ok = 0; m_valid = 0;
        end else begin
            bit mr, lr;
            mr = hm[1] && !hm[2];
            lr = hl[1] && !hl[2];
            if (mr) m_wd = 0; else if (m_wd < STOP) m_wd++;
            m_stall = (m_wd == STOP);
            m_lseen = m_lseen || lr;
            if (m_stall) begin
                m_mseen = 0; m_started = 0; m_prev_ok = 0; m_cnt = 0;
                m_valid = 0; m_code = 0;
            end else begin
                m_mseen = m_mseen || mr;
                if (lr) begin
                    if (m_started) begin
                        int c;
                        c = rcode(m_cnt);
                        if (!accepted(c, int'(sel))) begin m_valid = 0; m_code = 0; end
                        else if (m_prev_ok && m_cnt == m_prev) begin m_valid = 1; m_code = c; end
                        m_prev = m_cnt;
                        m_prev_ok = 1;
                    end
                    m_started = 1;
                    m_cnt = mr ? 1 : 0;
                end else if (mr && m_cnt < 4095) begin
                    m_cnt++;
                end
            end
            m_psave = m_stall || !(m_mseen && m_lseen);
            if (sel != 2'b11)  m_mode = int'(sel);
            else if (m_valid)  m_mode = auto_mode(m_code);
            else               m_mode = 0;
            hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = mclk;
            hl[2] = hl[1]; hl[1] = hl[0]; hl[0] = lrck;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            chk("R2 psave", int'(psave_o), int'(m_psave));
            chk("R3 valid", int'(valid_o), int'(m_valid));
            chk("R3 ratio", int'(ratio_o), m_code);
            chk("R4 mode",  int'(mode_o),  m_mode);
            if (cyc > 150000) begin
                chk("watchdog", 1, 0);
                done = 1;
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
            if (mclk_run) mclk = ~mclk;
            if (lrck_run) begin
                lcnt++;
                if (lcnt >= half) begin
                    lcnt = 0;
                    lrck = ~lrck;
                    if (lrck) half = alt ? ((half == ha) ? hb : ha) : half_req;
                end
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(5);
        chk("R1 psave", int'(psave_o), 1);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 ratio", int'(ratio_o), 0);
        chk("R1 mode",  int'(mode_o),  0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 psave after release", int'(psave_o), 1);
        chk("R10 mode auto invalid", int'(mode_o), 0);

        lrck_run = 1;
        wait_cyc(STOP + 50);
        chk("R2 psave with frame clock only", int'(psave_o), 1);
        mclk_run = 1;
        wait_cyc(2 * 256 * 5);
        chk("R2 psave after both clocks", int'(psave_o), 0);
        chk("R3 valid at 256", int'(valid_o), 1);
        chk("R3 code 256", int'(ratio_o), 3);
        chk("R4 auto 256 double", int'(mode_o), 1);

        half_req = 300;
        wait_cyc(2 * 300 * 5);
        chk("R6 unlisted valid", int'(valid_o), 0);
        chk("R6 unlisted code", int'(ratio_o), 0);
        chk("R10 auto invalid mode", int'(mode_o), 0);

        half_req = 512;
        wait_cyc(2 * 512 * 5);
        chk("R4 code 512", int'(ratio_o), 5);
        chk("R4 auto 512 normal", int'(mode_o), 0);

        half_req = 1536;
        wait_cyc(2 * 1536 * 5);
        chk("R4 code 1536", int'(ratio_o), 8);
        chk("R4 auto 1536 half", int'(mode_o), 2);

        sel = 2'b00;
        half_req = 1024;
        wait_cyc(2 * 1024 * 5);
        chk("R5 normal rejects 1024 valid", int'(valid_o), 0);
        chk("R6 rejected code", int'(ratio_o), 0);
        chk("R5 manual normal mode", int'(mode_o), 0);

        sel = 2'b10;
        wait_cyc(2 * 1024 * 3);
        chk("R5 half accepts 1024", int'(valid_o), 1);
        chk("R5 code 1024", int'(ratio_o), 7);
        chk("R5 manual half mode", int'(mode_o), 2);

        sel = 2'b01;
        half_req = 128;
        wait_cyc(2 * 128 * 6);
        chk("R5 double code 128", int'(ratio_o), 1);
        chk("R5 manual double mode", int'(mode_o), 1);

        sel = 2'b11;
        half_req = 256;
        wait_cyc(2 * 256 * 5);
        chk("R3 back to 256", int'(ratio_o), 3);
        ha = 256; hb = 512; alt = 1;
        wait_cyc(8000);
        chk("R9 alternating valid", int'(valid_o), 1);
        chk("R9 alternating code", int'(ratio_o), 3);
        alt = 0;

        mclk_run = 0;
        wait_cyc(STOP + 60);
        chk("R7 psave on stop", int'(psave_o), 1);
        chk("R7 valid on stop", int'(valid_o), 0);
        chk("R7 code on stop", int'(ratio_o), 0);
        chk("R10 mode on stop", int'(mode_o), 0);

        lrck_run = 0;
        mclk_run = 1;
        wait_cyc(12);
        chk("R8 resume psave", int'(psave_o), 0);
        chk("R8 resume valid", int'(valid_o), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule